// File: doc/BRIEF.md
# Custom Instruction Execution Unit

This block is an execution unit that sits beside a processor core and carries out user-defined instructions. The core hands it a command made of two 32-bit source operands and a 10-bit function selector over a valid/ready channel. The unit returns a single 32-bit result, together with an error bit, over a second valid/ready channel. The function selector is the concatenation {funct7, funct3} taken from an R-type instruction that uses one of the reserved custom major opcodes. The core decodes the instruction. This unit only sees the selector.

The unit keeps one instruction in flight at a time. Add, XOR and accumulate complete in one cycle. The low-product multiply runs through a fixed-latency pipeline. A 32-bit accumulator persists across instructions, so the accumulate result depends on earlier commands. Any selector without an operation completes at once with a zero result and the error bit set, so the core is never left waiting.

Top module: `cix_unit`

## Requirements
- R1: After reset, cmd_ready is 1, rsp_valid is 0 and the accumulator holds zero.
- R2: A command is taken only on a clock edge where cmd_valid and cmd_ready are both 1. cmd_ready is 0 from the edge after acceptance until the edge after the response handshake. Commands offered while cmd_ready is 0 have no effect.
- R3: While rsp_valid is 1 and rsp_ready is 0, rsp_valid stays 1 and rsp_data and rsp_err stay stable. After the edge where both are 1, rsp_valid is 0 and cmd_ready is 1.
- R4: Function 0 returns (a + b) mod 2^32 with rsp_err 0, and rsp_valid is 1 in the cycle right after acceptance.
- R5: Function 1 returns a XOR b with rsp_err 0, and rsp_valid is 1 in the cycle right after acceptance.
- R6: Function 2 returns the low 32 bits of the unsigned product a*b with rsp_err 0. rsp_valid first rises MUL_LAT+1 cycles after the accepting edge (4 at the default MUL_LAT of 3).
- R7: Function 3 sets the accumulator to accumulator + a (mod 2^32) and returns the new value, with rsp_err 0, one cycle after acceptance. Operand b is unused.
- R8: Every function code from 4 to 1023 returns rsp_data 0 with rsp_err 1, one cycle after acceptance, and leaves the accumulator unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd_valid | input | 1 | Command offered by the core |
| cmd_ready | output | 1 | Unit can accept a command |
| cmd_func | input | 10 | Function selector {funct7, funct3} |
| cmd_src_a | input | 32 | First source operand |
| cmd_src_b | input | 32 | Second source operand |
| rsp_valid | output | 1 | Result available |
| rsp_ready | input | 1 | Core takes the result |
| rsp_data | output | 32 | Result value |
| rsp_err | output | 1 | Function selector had no operation |

## Verification
The bench walks every one of the 1024 function selectors with several operand pairs. This separates the four decoded operations from each other and from the error path, and it catches a decode that ignores upper selector bits. For the arithmetic it uses all-ones, carry-chain and sign-bit operands, so that a modulo sum is told apart from a saturating one and a low product from a high or signed one. Repeated accumulate commands, mixed with rejected commands and error commands, show whether the accumulator changes only on accepted function-3 commands. Stalls of different lengths on rsp_ready, with new commands offered during the stall, test result holding and one-in-flight acceptance. Measured latencies separate the one-cycle path from the multiply pipeline.

// File: rtl/cix_pkg.sv
package cix_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_MUL  = 2'd1,
      ST_RESP = 2'd2
   } cix_state_e;

   localparam int unsigned FN_ADD = 0;
   localparam int unsigned FN_XOR = 1;
   localparam int unsigned FN_MUL = 2;
   localparam int unsigned FN_ACC = 3;
endpackage

// File: rtl/cix_alu.sv
module cix_alu
   import cix_pkg::*;
#(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned FUNC_W = 10
) (
   input  logic [FUNC_W-1:0] func,
   input  logic [DATA_W-1:0] src_a,
   input  logic [DATA_W-1:0] src_b,
   input  logic [DATA_W-1:0] acc_q,
   output logic [DATA_W-1:0] result,
   output logic              bad_func,
   output logic              use_mul,
   output logic              acc_wr
);
   always_comb begin
      result   = '0;
      bad_func = 1'b0;
      use_mul  = 1'b0;
      acc_wr   = 1'b0;
      case (func)
         FUNC_W'(FN_ADD): result = src_a + src_b;
         FUNC_W'(FN_XOR): result = src_a ^ src_b;
         FUNC_W'(FN_MUL): use_mul = 1'b1;
         FUNC_W'(FN_ACC): begin
            result = acc_q + src_a;
            acc_wr = 1'b1;
         end
         default: bad_func = 1'b1;
      endcase
   end
endmodule

// File: rtl/cix_mul_pipe.sv
module cix_mul_pipe #(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned LAT    = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [DATA_W-1:0] src_a,
   input  logic [DATA_W-1:0] src_b,
   output logic              done,
   output logic [DATA_W-1:0] prod
);
   localparam int unsigned PROD_W = 2 * DATA_W;

   logic [LAT-1:0]             vld_q;
   logic [LAT-1:0][DATA_W-1:0] stg_q;
   logic [PROD_W-1:0]          full_prod;

   assign full_prod = PROD_W'(src_a) * PROD_W'(src_b);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_q <= '0;
         stg_q <= '0;
      end else begin
         vld_q[0] <= start;
         if (start) stg_q[0] <= full_prod[DATA_W-1:0];
         for (int i = 1; i < int'(LAT); i++) begin
            vld_q[i] <= vld_q[i-1];
            stg_q[i] <= stg_q[i-1];
         end
      end
   end

   assign done = vld_q[LAT-1];
   assign prod = stg_q[LAT-1];
endmodule

// File: rtl/cix_ctrl.sv
module cix_ctrl
   import cix_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic cmd_valid,
   input  logic rsp_ready,
   input  logic use_mul,
   input  logic mul_done,
   output logic cmd_ready,
   output logic rsp_valid,
   output logic accept,
   output logic load_fast,
   output logic load_mul
);
   cix_state_e state_q, state_d;

   assign cmd_ready = (state_q == ST_IDLE);
   assign rsp_valid = (state_q == ST_RESP);
   assign accept    = cmd_valid & cmd_ready;
   assign load_fast = accept & ~use_mul;
   assign load_mul  = (state_q == ST_MUL) & mul_done;

   always_comb begin
      state_d = state_q;
      case (state_q)
         ST_IDLE: if (accept)    state_d = use_mul ? ST_MUL : ST_RESP;
         ST_MUL:  if (mul_done)  state_d = ST_RESP;
         ST_RESP: if (rsp_ready) state_d = ST_IDLE;
         default:                state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= ST_IDLE;
      else        state_q <= state_d;
   end
endmodule

// File: rtl/cix_unit.sv
module cix_unit #(
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned FUNC_W  = 10,
   parameter int unsigned MUL_LAT = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   output logic              cmd_ready,
   input  logic [FUNC_W-1:0] cmd_func,
   input  logic [DATA_W-1:0] cmd_src_a,
   input  logic [DATA_W-1:0] cmd_src_b,
   output logic              rsp_valid,
   input  logic              rsp_ready,
   output logic [DATA_W-1:0] rsp_data,
   output logic              rsp_err
);
   if (DATA_W < 1) begin : g_bad_data_w
      $error("cix_unit: DATA_W must be at least 1");
   end
   if (FUNC_W < 2) begin : g_bad_func_w
      $error("cix_unit: FUNC_W must be at least 2");
   end
   if (MUL_LAT < 1) begin : g_bad_lat
      $error("cix_unit: MUL_LAT must be at least 1");
   end

   logic [DATA_W-1:0] alu_res, mul_prod, acc_q, res_q;
   logic              alu_bad, use_mul, acc_wr, mul_done, err_q;
   logic              accept, load_fast, load_mul;

   cix_alu #(.DATA_W(DATA_W), .FUNC_W(FUNC_W)) u_alu (
      .func     (cmd_func),
      .src_a    (cmd_src_a),
      .src_b    (cmd_src_b),
      .acc_q    (acc_q),
      .result   (alu_res),
      .bad_func (alu_bad),
      .use_mul  (use_mul),
      .acc_wr   (acc_wr)
   );

   cix_mul_pipe #(.DATA_W(DATA_W), .LAT(MUL_LAT)) u_mul (
      .clk   (clk),
      .rst_n (rst_n),
      .start (accept & use_mul),
      .src_a (cmd_src_a),
      .src_b (cmd_src_b),
      .done  (mul_done),
      .prod  (mul_prod)
   );

   cix_ctrl u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmd_valid (cmd_valid),
      .rsp_ready (rsp_ready),
      .use_mul   (use_mul),
      .mul_done  (mul_done),
      .cmd_ready (cmd_ready),
      .rsp_valid (rsp_valid),
      .accept    (accept),
      .load_fast (load_fast),
      .load_mul  (load_mul)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_q <= '0;
         err_q <= 1'b0;
         acc_q <= '0;
      end else begin
         if (load_fast) begin
            res_q <= alu_res;
            err_q <= alu_bad;
         end else if (load_mul) begin
            res_q <= mul_prod;
            err_q <= 1'b0;
         end
         if (accept && acc_wr) acc_q <= alu_res;
      end
   end

   assign rsp_data = res_q;
   assign rsp_err  = err_q;
endmodule

// File: rtl/cix_unit_chk.sv
module cix_unit_chk #(
   parameter int unsigned DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cmd_valid,
   input logic              cmd_ready,
   input logic              rsp_valid,
   input logic              rsp_ready,
   input logic [DATA_W-1:0] rsp_data,
   input logic              rsp_err
);
   a_r3_hold_result: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data) && $stable(rsp_err)));

   a_r3_release: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_ready) |=> (!rsp_valid && cmd_ready));

   a_r2_one_in_flight: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> !cmd_ready);

   a_r2_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_ready) |=> !cmd_ready);

   a_r8_error_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_err) |-> (rsp_data == '0));
endmodule

bind cix_unit cix_unit_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/cix_unit_test.sv
module cix_unit_test;
   localparam int LAT = 3;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_valid = 1'b0;
   logic        cmd_ready;
   logic [9:0]  cmd_func = '0;
   logic [31:0] cmd_src_a = '0;
   logic [31:0] cmd_src_b = '0;
   logic        rsp_valid;
   logic        rsp_ready = 1'b0;
   logic [31:0] rsp_data;
   logic        rsp_err;

   int checks = 0;
   int errors = 0;
   logic [31:0] acc_m = '0;
   logic [31:0] pa [6];
   logic [31:0] pb [6];

   always #2 clk = ~clk;

   cix_unit #(.MUL_LAT(LAT)) uut (
      .clk, .rst_n, .cmd_valid, .cmd_ready, .cmd_func, .cmd_src_a,
      .cmd_src_b, .rsp_valid, .rsp_ready, .rsp_data, .rsp_err
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic string tag_of(input int f);
      case (f)
         0: return "R4";
         1: return "R5";
         2: return "R6";
         3: return "R7";
         default: return "R8";
      endcase
   endfunction

   task automatic run(input int f, input logic [31:0] a, input logic [31:0] b,
                      input int stall);
      logic [31:0] exp_d;
      logic        exp_e;
      int          lat;
      int          exp_lat;
      string       t;
      t = tag_of(f);
      exp_e = 1'b0;
      exp_lat = 1;
      case (f)
         0: exp_d = a + b;
         1: exp_d = a ^ b;
         2: begin exp_d = 32'(64'(a) * 64'(b)); exp_lat = LAT + 1; end
         3: begin acc_m = acc_m + a; exp_d = acc_m; end
         default: begin exp_d = '0; exp_e = 1'b1; end
      endcase
      cmd_func = 10'(f); cmd_src_a = a; cmd_src_b = b; cmd_valid = 1'b1;
      while (!cmd_ready) @(negedge clk);
      @(negedge clk);
      cmd_valid = 1'b0;
      lat = 1;
      while (!rsp_valid && lat < 50) begin @(negedge clk); lat++; end
      chk(lat == exp_lat, t, 32'(lat), 32'(exp_lat));
      chk(rsp_data == exp_d, t, rsp_data, exp_d);
      chk(rsp_err == exp_e, t, 32'(rsp_err), 32'(exp_e));
      for (int s = 0; s < stall; s++) begin
         // R2: rejected command that would disturb the accumulator
         cmd_func = 10'd3; cmd_src_a = 32'h1234_5678; cmd_valid = 1'b1;
         @(negedge clk);
         chk(rsp_valid && rsp_data == exp_d && rsp_err == exp_e, "R3",
             rsp_data, exp_d);
         chk(!cmd_ready, "R2", 32'(cmd_ready), 32'd0);
      end
      cmd_valid = 1'b0;
      rsp_ready = 1'b1;
      @(negedge clk);
      rsp_ready = 1'b0;
      chk(!rsp_valid && cmd_ready, "R3", {rsp_valid, cmd_ready}, 32'd1);
   endtask

   initial begin
      pa[0] = 32'h0000_0000; pb[0] = 32'h0000_0000;
      pa[1] = 32'hFFFF_FFFF; pb[1] = 32'h0000_0001;
      pa[2] = 32'h8000_0000; pb[2] = 32'h8000_0000;
      pa[3] = 32'hFFFF_FFFF; pb[3] = 32'hFFFF_FFFF;
      pa[4] = 32'h1234_5678; pb[4] = 32'h9ABC_DEF0;
      pa[5] = 32'h0001_0001; pb[5] = 32'h0000_FFFF;
      repeat (3) @(negedge clk);
      chk(cmd_ready == 1'b1, "R1", 32'(cmd_ready), 32'd1);
      chk(rsp_valid == 1'b0, "R1", 32'(rsp_valid), 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(cmd_ready && !rsp_valid, "R1", {rsp_valid, cmd_ready}, 32'd1);
      run(3, 32'd0, 32'hDEAD_BEEF, 0);   // R1: accumulator starts at zero
      for (int f = 0; f < 4; f++)
         for (int p = 0; p < 6; p++)
            run(f, pa[p], pb[p], p % 3);
      for (int f = 0; f < 1024; f++) begin
         run(f, 32'h0000_0007 + 32'(f), 32'hF000_0003, f % 3);
         if (f == 700) run(3, 32'd0, 32'd0, 0); // R8: accumulator kept
      end
      run(3, 32'd1, 32'd0, 2);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule